// File: doc/BRIEF.md
# Converter Sample Buffer with Host Status and Interrupt

This block buffers samples from an analog-to-digital converter until a host reads them over a small 8/16-bit register port. Samples arrive on a valid/ready stream from the converter side. The block never stalls the converter: `smp_ready` is held high, and a sample that arrives while the buffer is full is discarded and recorded in a sticky overflow bit. The host pops samples from a data register. It reads fill state from a combined range/status byte in which the full and half-full flags are active-low. The same byte carries a 3-bit gain-range code that the host may rewrite.

The buffer is flushed by a 0, 1, 0 sequence on an enable bit of the interrupt-control register. The flush happens when that bit falls. A select bit in the same register chooses the interrupt source: either each accepted conversion or the half-full condition. A rising edge of the selected source latches a level interrupt request. The request holds until the host writes anything to the clear register.

Register select `bus_addr`: 0 = sample data (read pops), 1 = range/status, 2 = interrupt control, 3 = interrupt clear.

Top module: `adc_sample_buffer`

## Requirements
- R1: After reset the status byte reads 0x60: bit6 = 1 and bit5 = 1 (not full, not half), bit4 = 0 (no data), bit3 = 0, range 0. `irq_req` is low.
- R2: Samples are returned on reads of register 0 in arrival order, and up to DEPTH samples are held.
- R3: Status bit6 reads 0 exactly when the buffer holds DEPTH samples.
- R4: Status bit5 reads 0 exactly when the buffer holds at least DEPTH/2 samples.
- R5: Status bit4 reads 1 exactly when at least one sample is stored.
- R6: Writing register 1 sets the range code in bits 2..0 from write-data bits 2..0, and reads return it. The write leaves bits 7..3 unaffected.
- R7: Interrupt-control bit2 flushes the buffer on its falling edge. Raising the bit alone leaves the contents intact.
- R8: A sample offered while the buffer is full is dropped, and status bit3 (overflow) sets and stays set until the next flush.
- R9: Reading register 0 while the buffer is empty returns the last sample popped and does not advance the read position.
- R10: Interrupt-control bit0 selects the source (0 = accepted conversion, 1 = half-full). A rising edge of the selected source sets `irq_req`. A half-full level that persists does not set it again.
- R11: Any write to register 3 drops `irq_req` on the next clock edge.
- R12: Status bit7 mirrors the `conv_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Converter sample valid |
| smp_data | input | 16 | Converter sample |
| smp_ready | output | 1 | Always 1; full-buffer samples are dropped |
| conv_busy | input | 1 | Converter busy indication |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on register 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| irq_req | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are the full boundary with an extra sample offered, and a half-full interrupt that must not re-arm after a clear while the level persists. The bench uses a 16-deep configuration. It sweeps every fill level from empty to full and past it, checking the three fill flags at each level against counts computed in the bench. It then clears the interrupt while the buffer sits above the half mark and confirms that the request stays low.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ICTL = 2'd2,
    SEL_ICLR = 2'd3
  } reg_sel_e;

  localparam int STAT_BUSY  = 7;
  localparam int STAT_FULLN = 6;
  localparam int STAT_HALFN = 5;
  localparam int STAT_AVAIL = 4;
  localparam int STAT_OVF   = 3;
  localparam int RANGE_W    = 3;
  localparam int ICTL_SRC   = 0;
  localparam int ICTL_FLUSH = 2;
endpackage

// File: rtl/sample_store.sv
module sample_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH):0]     count,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic                       full,
  output logic                       half,
  output logic                       empty,
  output logic                       ovf,
  output logic                       push_acc
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic              pop_acc;

  assign full     = (count == CNT_W'(DEPTH));
  assign half     = (count >= CNT_W'(DEPTH / 2));
  assign empty    = (count == '0);
  assign push_acc = push & ~full & ~flush;
  assign pop_acc  = pop & ~empty & ~flush;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_acc)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push_acc) - CNT_W'(pop_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) ovf <= 1'b0;
    else if (push && full) ovf <= 1'b1;
  end
endmodule

// File: rtl/host_regs.sv
module host_regs
  import adcbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic [DATA_W-1:0] head,
  input  logic              full,
  input  logic              half,
  input  logic              empty,
  input  logic              ovf,
  input  logic              busy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pop,
  output logic              flush,
  output logic              src_half,
  output logic              clr_wr
);
  logic [RANGE_W-1:0] range_q;
  logic               flush_en, flush_en_d;
  logic [DATA_W-1:0]  last_q;
  logic [7:0]         stat_byte;
  reg_sel_e           sel;

  assign sel    = reg_sel_e'(bus_addr);
  assign pop    = bus_rd && (sel == SEL_DATA);
  assign clr_wr = bus_wr && (sel == SEL_ICLR);
  assign flush  = flush_en_d & ~flush_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_q    <= '0;
      flush_en   <= 1'b0;
      flush_en_d <= 1'b0;
      src_half   <= 1'b0;
      last_q     <= '0;
    end else begin
      flush_en_d <= flush_en;
      if (bus_wr && sel == SEL_STAT) range_q <= bus_wdata[RANGE_W-1:0];
      if (bus_wr && sel == SEL_ICTL) begin
        flush_en <= bus_wdata[ICTL_FLUSH];
        src_half <= bus_wdata[ICTL_SRC];
      end
      if (pop && !empty) last_q <= head;
    end
  end

  always_comb begin
    stat_byte             = '0;
    stat_byte[STAT_BUSY]  = busy;
    stat_byte[STAT_FULLN] = ~full;
    stat_byte[STAT_HALFN] = ~half;
    stat_byte[STAT_AVAIL] = ~empty;
    stat_byte[STAT_OVF]   = ovf;
    stat_byte[RANGE_W-1:0] = range_q;
    unique case (sel)
      SEL_DATA: bus_rdata = empty ? last_q : head;
      SEL_STAT: bus_rdata = DATA_W'(stat_byte);
      SEL_ICTL: bus_rdata = DATA_W'({5'b0, flush_en, 1'b0, src_half});
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src_half,
  input  logic eoc,
  input  logic half,
  input  logic clr,
  output logic irq
);
  logic cond, cond_q;

  assign cond = src_half ? half : eoc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cond_q <= cond;
      if (clr) irq <= 1'b0;
      else if (cond && !cond_q) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              smp_ready,
  input  logic              conv_busy,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] head;
  logic [AW:0]       fill_cnt;
  logic [AW-1:0]     rd_ptr;
  logic full, half, empty, ovf, push_acc;
  logic pop, flush, src_half, clr_wr;

  assign smp_ready = 1'b1;

  sample_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(smp_valid), .push_data(smp_data), .pop(pop),
    .head(head), .count(fill_cnt), .rd_ptr(rd_ptr),
    .full(full), .half(half), .empty(empty), .ovf(ovf), .push_acc(push_acc)
  );

  host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .head(head), .full(full), .half(half), .empty(empty), .ovf(ovf), .busy(conv_busy),
    .bus_rdata(bus_rdata), .pop(pop), .flush(flush), .src_half(src_half), .clr_wr(clr_wr)
  );

  irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .src_half(src_half), .eoc(push_acc),
    .half(half), .clr(clr_wr), .irq(irq_req)
  );
endmodule

// File: rtl/adc_sample_buffer_chk.sv
module adc_sample_buffer_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW:0]   fill_cnt,
  input logic [AW-1:0] rd_ptr,
  input logic          full,
  input logic          empty,
  input logic          ovf,
  input logic          flush,
  input logic          pop,
  input logic          smp_valid,
  input logic          clr_wr,
  input logic          irq_req
);
  // R3 R5
  fill_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && smp_valid && !pop && !flush) |=> $stable(fill_cnt));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> ovf);

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !flush) |=> $stable(rd_ptr));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !irq_req);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !clr_wr) |=> irq_req);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

bind adc_sample_buffer adc_sample_buffer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .rd_ptr(rd_ptr),
  .full(full), .empty(empty), .ovf(ovf), .flush(flush), .pop(pop),
  .smp_valid(smp_valid), .clr_wr(clr_wr), .irq_req(irq_req)
);

// File: tb/test_adc_sample_buffer.sv
module test_adc_sample_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic smp_ready;
  logic conv_busy = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sample_buffer #(.DATA_W(DW), .DEPTH(DEP)) i_adc_sample_buffer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .conv_busy(conv_busy), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk); smp_valid = 1'b1; smp_data = v;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_flush(input logic src);
    wr(2'd2, {5'b0, 1'b1, 1'b0, src});
    wr(2'd2, {5'b0, 1'b0, 1'b0, src});
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(16'hA000 + i * 37);
  endfunction

  function automatic logic [7:0] exp_stat(input int n, input logic o, input logic [2:0] rg);
    return {1'b0, (n != DEP), (n < DEP/2), (n != 0), o, rg};
  endfunction

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, v); check("R1 status", v, 32'h60);
    check("R1 irq", irq_req, 0);
    check("R1 ready", smp_ready, 1);

    // R3 R4 R5 sweep of fill levels
    for (int k = 0; k <= DEP; k++) begin
      do_flush(1'b0);
      for (int i = 0; i < k; i++) push(pat(i));
      rd(2'd1, v);
      check($sformatf("R3/R4/R5 level %0d", k), v[7:0], exp_stat(k, 1'b0, 3'd0));
    end

    // R8 overflow when full
    push(16'hDEAD);
    rd(2'd1, v); check("R8 overflow set", v[7:0], exp_stat(DEP, 1'b1, 3'd0));
    // R2 order, extra sample dropped
    for (int i = 0; i < DEP; i++) begin
      rd(2'd0, v); check($sformatf("R2 order %0d", i), v, pat(i));
    end
    rd(2'd1, v); check("R8 overflow sticky", v[7:0], exp_stat(0, 1'b1, 3'd0));
    // R9 empty read returns last value
    rd(2'd0, v); check("R9 empty read", v, pat(DEP-1));
    push(16'h1234);
    rd(2'd0, v); check("R9 pointer kept", v, 16'h1234);
    do_flush(1'b0);
    rd(2'd1, v); check("R8 overflow cleared", v[7:0], exp_stat(0, 1'b0, 3'd0));

    // R6 range field
    for (int r = 0; r < 8; r++) begin
      wr(2'd1, 8'(8'hF8 | r));
      rd(2'd1, v); check($sformatf("R6 range %0d", r), v[7:0], exp_stat(0, 1'b0, 3'(r)));
    end
    wr(2'd1, 8'h00);

    // R12 busy mirror
    conv_busy = 1'b1; rd(2'd1, v); check("R12 busy high", v[7], 1);
    conv_busy = 1'b0; rd(2'd1, v); check("R12 busy low", v[7], 0);

    // R7 rising edge alone keeps data
    push(16'h0055); push(16'h0066);
    wr(2'd2, 8'h04); @(negedge clk);
    rd(2'd1, v); check("R7 rise keeps", v[7:0], exp_stat(2, 1'b0, 3'd0));
    wr(2'd2, 8'h00); @(negedge clk);
    rd(2'd1, v); check("R7 fall flushes", v[7:0], exp_stat(0, 1'b0, 3'd0));

    // R10 eoc source, R11 clear
    wr(2'd3, 8'h00);
    check("R11 idle low", irq_req, 0);
    push(16'h0077); @(negedge clk);
    check("R10 eoc sets irq", irq_req, 1);
    wr(2'd3, 8'h5A);
    check("R11 clear drops", irq_req, 0);

    // R10 half source
    do_flush(1'b1);
    wr(2'd3, 8'h00);
    for (int i = 0; i < DEP/2 - 1; i++) push(pat(i));
    @(negedge clk);
    check("R10 below half no irq", irq_req, 0);
    push(pat(99)); @(negedge clk); @(negedge clk);
    check("R10 half sets irq", irq_req, 1);
    wr(2'd3, 8'h00); @(negedge clk); @(negedge clk);
    check("R11 level half no rearm", irq_req, 0);
    push(pat(100)); @(negedge clk);
    check("R10 eoc ignored in half mode", irq_req, 0);

    finish_run();
  end
endmodule